// File: doc/BRIEF.md
# Digital Video Byte-Stream Timing Recovery (625-line)

This block watches an 8-bit component video byte stream, as carried on a 27 MHz interface for 625-line, 50-field video, and recovers the picture timing from the reference codes embedded in the stream. A reference code is the four-byte run 0xFF, 0x00, 0x00 followed by a status byte. The status byte carries a field bit, a vertical-blanking bit and a bit that tells the start of blanking (end of active video) apart from the start of active video. The block only trusts a code whose status byte has a correct set of protection bits. A bad code is reported and otherwise ignored.

From the trusted codes the block rebuilds a horizontal byte counter and a line counter. It drives field, vertical-blanking, active-video and luma-valid strobes that stay aligned with a delayed copy of the input byte. It holds every strobe and counter at zero until it has seen two good end-of-line codes exactly one line length apart. After that it also reports any end-of-line code that arrives off the expected line length. A line is 1728 bytes by default: 288 bytes of blanking, then 1440 bytes of active video in Cb Y Cr Y order. The frame has 625 lines.

Top module: `vid_sync_decoder`

## Requirements
- R1: `dout` carries the input byte captured on clock edge n after clock edge n+3 (four edges including the capture). Every other output is aligned to that same byte.
- R2: A status byte that follows 0xFF 0x00 0x00 is valid only when bit 7 is 1 and bits 3..0 equal {V^H, F^H, F^V, F^V^H}, with F = bit 6, V = bit 5 and H = bit 4. An invalid one raises `code_error_o` for exactly the cycle in which its 0xFF byte is on `dout`. Such a code changes no counter and no flag.
- R3: `hcount_o` is 0 on the 0xFF byte of each valid code with H=1 (end of line). It rises by one on each later byte and holds at its all-ones value, which has clog2(LINE_LEN)+1 bits.
- R4: After reset, `field_o`, `vblank_o`, `active_o`, `luma_valid_o`, `luma_o`, `hcount_o` and `line_o` stay 0 until the 0xFF byte of a valid H=1 code that comes exactly LINE_LEN bytes after the previous valid H=1 code. From then on they stay enabled.
- R5: `field_o` and `vblank_o` show the F and V bits of the latest valid code (H either value). They change on that code's 0xFF byte.
- R6: `active_o` is 1 exactly when the outputs are enabled, V is 0, and BLANK_LEN <= `hcount_o` < LINE_LEN.
- R7: `luma_valid_o` is 1 on active bytes at odd offsets from the first active byte. `luma_o` equals `dout` there and is 0 elsewhere.
- R8: `line_o` moves on each valid H=1 code. It goes to 1 after FRAME_LINES and otherwise rises by one.
- R9: On a valid H=1 code, F going from 0 to 1 (against the previous valid H=1 code) loads FIELD2_FIRST into `line_o`. Otherwise, V going from 1 to 0 loads VBL1_LAST+1 when F=0 and VBL2_LAST+1 when F=1. This replaces the R8 step.
- R10: `timing_error_o` pulses on the 0xFF byte of a valid H=1 code when an earlier valid H=1 code has been seen since reset and it was not exactly LINE_LEN bytes earlier.
- R11: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| din | input | 8 | Input byte stream |
| dout | output | 8 | Input byte delayed to match the strobes |
| field_o | output | 1 | Field bit of the latest valid code |
| vblank_o | output | 1 | Vertical-blanking bit of the latest valid code |
| active_o | output | 1 | Byte belongs to active video |
| luma_valid_o | output | 1 | Byte is a luma sample |
| luma_o | output | 8 | Luma byte when valid, else 0 |
| hcount_o | output | clog2(LINE_LEN)+1 | Byte position since the last end-of-line code |
| line_o | output | clog2(FRAME_LINES+1) | Recovered line number |
| code_error_o | output | 1 | Reference code with bad status byte |
| timing_error_o | output | 1 | End-of-line code at the wrong distance |

## Verification
Some properties are checked on every cycle by assertions:
- the four-edge byte delay;
- that both error flags last a single cycle;
- that the horizontal count steps by one or holds;
- that the line number moves only where the horizontal count is zero;
- that active and luma strobes stay inside their window and keep the alternating pattern.

Other behaviour only the bench scenarios can show. The protection check is swept over all 256 status bytes. The lock delay is shown with a short first line. A corrupted end-of-line code must be ignored while the counter runs on and saturates. The line number must be realigned by field and blanking edges when the stream starts in mid-frame.

// File: rtl/vsd_pkg.sv
package vsd_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic f;
    logic v;
    logic h;
  } vsd_flags_t;

  function automatic logic [3:0] vsd_prot(input vsd_flags_t x);
    return {x.v ^ x.h, x.f ^ x.h, x.f ^ x.v, x.f ^ x.v ^ x.h};
  endfunction
endpackage

// File: rtl/vsd_rst_sync.sv
module vsd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/vsd_code_finder.sv
module vsd_code_finder
  import vsd_pkg::*;
#(
  parameter int LAG = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] lagged,
  output logic              code_hit,
  output logic              code_bad,
  output vsd_flags_t        code_flags
);
  logic [BYTE_W-1:0] tap_q [LAG];
  logic [BYTE_W-1:0] tap_d [LAG];
  logic              preamble;
  logic              status_ok;

  // delay line: tap 0 is the newest byte, tap LAG-1 the oldest
  generate
    for (genvar i = 0; i < LAG; i++) begin : g_tap
      if (i == 0) begin : g_first
        assign tap_d[i] = din;
      end else begin : g_rest
        assign tap_d[i] = tap_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tap_q[i] <= '0;
        else        tap_q[i] <= tap_d[i];
      end
    end
  endgenerate

  always_comb begin
    preamble   = (tap_q[2] == 8'hFF) && (tap_q[1] == 8'h00) && (tap_q[0] == 8'h00);
    code_flags = vsd_flags_t'(din[6:4]);
    status_ok  = din[7] && (din[3:0] == vsd_prot(code_flags));
    code_hit   = preamble && status_ok;
    code_bad   = preamble && !status_ok;
  end

  assign lagged = tap_q[LAG-1];
endmodule

// File: rtl/vsd_line_timer.sv
module vsd_line_timer
  import vsd_pkg::*;
#(
  parameter int LINE_LEN     = 1728,
  parameter int FRAME_LINES  = 625,
  parameter int VBL1_LAST    = 22,
  parameter int FIELD2_FIRST = 313,
  parameter int VBL2_LAST    = 335,
  parameter int HW           = 12,
  parameter int LW           = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          code_hit,
  input  vsd_flags_t    code_flags,
  output logic [HW-1:0] hcnt,
  output logic [LW-1:0] line,
  output logic          fld,
  output logic          vbl,
  output logic          locked,
  output logic          terr
);
  localparam logic [HW-1:0] H_LAST  = HW'(LINE_LEN - 1);
  localparam logic [HW-1:0] H_MAX   = {HW{1'b1}};
  localparam logic [LW-1:0] L_LAST  = LW'(FRAME_LINES);
  localparam logic [LW-1:0] L_F2    = LW'(FIELD2_FIRST);
  localparam logic [LW-1:0] L_ACT1  = LW'(VBL1_LAST + 1);
  localparam logic [LW-1:0] L_ACT2  = LW'(VBL2_LAST + 1);

  logic [HW-1:0] hcnt_d;
  logic [LW-1:0] line_d;
  logic          fld_d, vbl_d, locked_d, terr_d;
  logic          seen_q, seen_d;
  logic          pf_q, pv_q, pf_d, pv_d;
  logic          eav, on_time;

  always_comb begin
    eav      = code_hit && code_flags.h;
    on_time  = (hcnt == H_LAST);
    hcnt_d   = hcnt;
    line_d   = line;
    fld_d    = fld;
    vbl_d    = vbl;
    pf_d     = pf_q;
    pv_d     = pv_q;
    seen_d   = seen_q;
    locked_d = locked;
    terr_d   = 1'b0;

    if (eav)                hcnt_d = '0;
    else if (hcnt != H_MAX) hcnt_d = hcnt + HW'(1);

    if (code_hit) begin
      fld_d = code_flags.f;
      vbl_d = code_flags.v;
    end

    if (eav) begin
      pf_d     = code_flags.f;
      pv_d     = code_flags.v;
      seen_d   = 1'b1;
      terr_d   = seen_q && !on_time;
      locked_d = locked || (seen_q && on_time);
      if (code_flags.f && !pf_q)      line_d = L_F2;
      else if (pv_q && !code_flags.v) line_d = code_flags.f ? L_ACT2 : L_ACT1;
      else if (line == L_LAST)        line_d = LW'(1);
      else                            line_d = line + LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt   <= '0;
      line   <= '0;
      fld    <= 1'b0;
      vbl    <= 1'b0;
      pf_q   <= 1'b0;
      pv_q   <= 1'b0;
      seen_q <= 1'b0;
      locked <= 1'b0;
      terr   <= 1'b0;
    end else begin
      hcnt   <= hcnt_d;
      line   <= line_d;
      fld    <= fld_d;
      vbl    <= vbl_d;
      pf_q   <= pf_d;
      pv_q   <= pv_d;
      seen_q <= seen_d;
      locked <= locked_d;
      terr   <= terr_d;
    end
  end
endmodule

// File: rtl/vsd_out_stage.sv
module vsd_out_stage
  import vsd_pkg::*;
#(
  parameter int LINE_LEN  = 1728,
  parameter int BLANK_LEN = 288,
  parameter int HW        = 12,
  parameter int LW        = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] lagged,
  input  logic              code_bad,
  input  logic [HW-1:0]     hcnt,
  input  logic [LW-1:0]     line,
  input  logic              fld,
  input  logic              vbl,
  input  logic              locked,
  output logic [BYTE_W-1:0] dout,
  output logic              field_o,
  output logic              vblank_o,
  output logic              active_o,
  output logic              luma_valid_o,
  output logic [BYTE_W-1:0] luma_o,
  output logic [HW-1:0]     hcount_o,
  output logic [LW-1:0]     line_o,
  output logic              code_error_o
);
  localparam logic [HW-1:0] H_ACT0 = HW'(BLANK_LEN);
  localparam logic [HW-1:0] H_END  = HW'(LINE_LEN);
  localparam logic          PHASE  = 1'(BLANK_LEN % 2);

  logic [BYTE_W-1:0] dout_d;
  logic              cerr_d;
  logic              in_window;

  always_comb begin
    dout_d = lagged;
    cerr_d = code_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout         <= '0;
      code_error_o <= 1'b0;
    end else begin
      dout         <= dout_d;
      code_error_o <= cerr_d;
    end
  end

  always_comb begin
    in_window    = (hcnt >= H_ACT0) && (hcnt < H_END);
    field_o      = locked && fld;
    vblank_o     = locked && vbl;
    active_o     = locked && !vbl && in_window;
    luma_valid_o = active_o && (hcnt[0] ^ PHASE);
    luma_o       = luma_valid_o ? dout : '0;
    hcount_o     = locked ? hcnt : '0;
    line_o       = locked ? line : '0;
  end
endmodule

// File: rtl/vid_sync_decoder.sv
module vid_sync_decoder
  import vsd_pkg::*;
#(
  parameter int LINE_LEN     = 1728,
  parameter int BLANK_LEN    = 288,
  parameter int FRAME_LINES  = 625,
  parameter int VBL1_LAST    = 22,
  parameter int FIELD2_FIRST = 313,
  parameter int VBL2_LAST    = 335,
  localparam int HW          = $clog2(LINE_LEN) + 1,
  localparam int LW          = $clog2(FRAME_LINES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    din,
  output logic [7:0]    dout,
  output logic          field_o,
  output logic          vblank_o,
  output logic          active_o,
  output logic          luma_valid_o,
  output logic [7:0]    luma_o,
  output logic [HW-1:0] hcount_o,
  output logic [LW-1:0] line_o,
  output logic          code_error_o,
  output logic          timing_error_o
);
  logic              srst_n;
  logic [BYTE_W-1:0] lagged;
  logic              code_hit, code_bad;
  vsd_flags_t        code_flags;
  logic [HW-1:0]     hcnt;
  logic [LW-1:0]     line;
  logic              fld, vbl, locked;

  vsd_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  vsd_code_finder #(.LAG(3)) u_find (
    .clk        (clk),
    .rst_n      (srst_n),
    .din        (din),
    .lagged     (lagged),
    .code_hit   (code_hit),
    .code_bad   (code_bad),
    .code_flags (code_flags)
  );

  vsd_line_timer #(
    .LINE_LEN     (LINE_LEN),
    .FRAME_LINES  (FRAME_LINES),
    .VBL1_LAST    (VBL1_LAST),
    .FIELD2_FIRST (FIELD2_FIRST),
    .VBL2_LAST    (VBL2_LAST),
    .HW           (HW),
    .LW           (LW)
  ) u_timer (
    .clk        (clk),
    .rst_n      (srst_n),
    .code_hit   (code_hit),
    .code_flags (code_flags),
    .hcnt       (hcnt),
    .line       (line),
    .fld        (fld),
    .vbl        (vbl),
    .locked     (locked),
    .terr       (timing_error_o)
  );

  vsd_out_stage #(
    .LINE_LEN  (LINE_LEN),
    .BLANK_LEN (BLANK_LEN),
    .HW        (HW),
    .LW        (LW)
  ) u_out (
    .clk          (clk),
    .rst_n        (srst_n),
    .lagged       (lagged),
    .code_bad     (code_bad),
    .hcnt         (hcnt),
    .line         (line),
    .fld          (fld),
    .vbl          (vbl),
    .locked       (locked),
    .dout         (dout),
    .field_o      (field_o),
    .vblank_o     (vblank_o),
    .active_o     (active_o),
    .luma_valid_o (luma_valid_o),
    .luma_o       (luma_o),
    .hcount_o     (hcount_o),
    .line_o       (line_o),
    .code_error_o (code_error_o)
  );
endmodule

// File: rtl/vsd_checker.sv
module vsd_checker #(
  parameter int LINE_LEN  = 1728,
  parameter int BLANK_LEN = 288,
  parameter int HW        = 12,
  parameter int LW        = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    din,
  input logic [7:0]    dout,
  input logic          vblank_o,
  input logic          active_o,
  input logic          luma_valid_o,
  input logic [HW-1:0] hcount_o,
  input logic [LW-1:0] line_o,
  input logic          code_error_o,
  input logic          timing_error_o
);
  localparam logic [HW-1:0] H_MAX = {HW{1'b1}};
  logic [2:0] cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cyc <= '0;
    else if (cyc != 3'd7) cyc <= cyc + 3'd1;
  end

  // R1
  dout_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd5) |-> dout == $past(din, 4));

  // R2
  cerr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_error_o |=> !code_error_o);

  // R10
  terr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timing_error_o |=> !timing_error_o);

  // R3
  hcnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd1 && hcount_o != '0 && $past(hcount_o) != '0 && $past(hcount_o) != H_MAX)
      |-> hcount_o == $past(hcount_o) + HW'(1));

  // R6
  active_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> (!vblank_o && hcount_o >= HW'(BLANK_LEN) && hcount_o < HW'(LINE_LEN)));

  // R7
  luma_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    luma_valid_o |=> !luma_valid_o);

  // R7
  luma_in_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    luma_valid_o |-> active_o);

  // R8
  line_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd1 && line_o != $past(line_o)) |-> hcount_o == '0);
endmodule

bind vid_sync_decoder vsd_checker #(
  .LINE_LEN  (LINE_LEN),
  .BLANK_LEN (BLANK_LEN),
  .HW        (HW),
  .LW        (LW)
) u_chk (
  .clk            (clk),
  .rst_n          (srst_n),
  .din            (din),
  .dout           (dout),
  .vblank_o       (vblank_o),
  .active_o       (active_o),
  .luma_valid_o   (luma_valid_o),
  .hcount_o       (hcount_o),
  .line_o         (line_o),
  .code_error_o   (code_error_o),
  .timing_error_o (timing_error_o)
);

// File: tb/vid_sync_decoder_bench.sv
module vid_sync_decoder_bench;
  localparam int LL = 32, BL = 12, NL = 12, V1 = 2, F2 = 7, V2 = 8;
  localparam int HW = $clog2(LL) + 1;
  localparam int LW = $clog2(NL + 1);
  localparam int HMAX = (1 << HW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [7:0]    din;
  logic [7:0]    dout, luma_o;
  logic          field_o, vblank_o, active_o, luma_valid_o;
  logic [HW-1:0] hcount_o;
  logic [LW-1:0] line_o;
  logic          code_error_o, timing_error_o;

  always #10 clk = ~clk;

  vid_sync_decoder #(
    .LINE_LEN(LL), .BLANK_LEN(BL), .FRAME_LINES(NL),
    .VBL1_LAST(V1), .FIELD2_FIRST(F2), .VBL2_LAST(V2)
  ) u_vid_sync_decoder (
    .clk(clk), .rst_n(rst_n), .din(din), .dout(dout),
    .field_o(field_o), .vblank_o(vblank_o), .active_o(active_o),
    .luma_valid_o(luma_valid_o), .luma_o(luma_o),
    .hcount_o(hcount_o), .line_o(line_o),
    .code_error_o(code_error_o), .timing_error_o(timing_error_o)
  );

  typedef struct packed {
    logic [7:0] d;
    logic [7:0] lu;
    int         h;
    int         ln;
    bit ck; bit ckte; bit lk; bit rl; bit ce; bit te;
    bit f;  bit v;    bit a;  bit lv;
  } exp_t;

  exp_t hist [0:4095];
  int   wr, total, bad;

  function automatic bit fF(int l); return l >= F2; endfunction
  function automatic bit fV(int l); return (l <= V1) || (l >= F2 && l <= V2); endfunction
  function automatic logic [7:0] xy(bit f, bit v, bit h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction
  function automatic logic [7:0] gen(int l, int p);
    if (p == 0 || p == BL - 4) return 8'hFF;
    if (p == 1 || p == 2 || p == BL - 3 || p == BL - 2) return 8'h00;
    if (p == 3) return xy(fF(l), fV(l), 1'b1);
    if (p == BL - 1) return xy(fF(l), fV(l), 1'b0);
    if (p < BL || fV(l)) return (p % 2 == 1) ? 8'h10 : 8'h80;
    return 8'(16 + ((l * 7 + p) % 208));
  endfunction

  task automatic cmp(int act, int exp, string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d (entry %0d)", tag, act, exp, wr - 4);
    end
  endtask

  task automatic check_entry(exp_t e);
    string t;
    cmp(dout, e.d, "R1 dout");
    cmp(code_error_o, e.ce, "R2 code_error");
    if (e.ckte) cmp(timing_error_o, e.te, "R10 timing_error");
    if (e.ck) begin
      t = e.lk ? "" : "R4 unlocked ";
      cmp(field_o, e.f, {t, "R5 field"});
      cmp(vblank_o, e.v, {t, "R5 vblank"});
      cmp(active_o, e.a, {t, "R6 active"});
      cmp(luma_valid_o, e.lv, {t, "R7 luma_valid"});
      cmp(luma_o, e.lu, {t, "R7 luma"});
      cmp(hcount_o, e.h, {t, "R3 hcount"});
      cmp(line_o, e.ln, {t, e.rl ? "R9 line" : "R8 line"});
    end
  endtask

  task automatic push(logic [7:0] b, exp_t e);
    @(negedge clk);
    if (wr >= 4) check_entry(hist[wr - 4]);
    din = b;
    hist[wr] = e;
    wr++;
  endtask

  function automatic exp_t plain(logic [7:0] b);
    exp_t e = '0;
    e.d = b; e.ck = 1'b1; e.ckte = 1'b1;
    return e;
  endfunction

  task automatic send_line(int l, int n, bit lk, int ln, bit rl, int hofs, bit te0, bit xbad);
    for (int p = 0; p < n; p++) begin
      logic [7:0] b;
      exp_t e;
      int hh;
      b = gen(l, p);
      if (xbad && p == 3) b = b ^ 8'h01;
      e = plain(b);
      e.ce = xbad && p == 0;
      e.te = te0 && p == 0;
      e.lk = lk;
      e.rl = rl;
      if (lk) begin
        hh = p + hofs;
        if (hh > HMAX) hh = HMAX;
        e.h  = hh;
        e.ln = ln;
        e.f  = fF(l);
        e.v  = fV(l);
        e.a  = !fV(l) && hh >= BL && hh < LL;
        e.lv = e.a && ((hh - BL) % 2 == 1);
        e.lu = e.lv ? b : 8'h00;
      end
      push(b, e);
    end
  endtask

  task automatic idle(int n, bit lk, int h0, int ln, bit f, bit v, bit ck);
    for (int k = 0; k < n; k++) begin
      exp_t e = plain(8'h10);
      e.ck = ck; e.ckte = ck; e.lk = lk;
      if (lk) begin
        e.h  = (h0 + k > HMAX) ? HMAX : h0 + k;
        e.ln = ln; e.f = f; e.v = v;
      end
      push(8'h10, e);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    din   = 8'h00;
    repeat (3) @(negedge clk);
    cmp(dout, 0, "R11 reset dout");
    cmp({field_o, vblank_o, active_o, luma_valid_o}, 0, "R11 reset strobes");
    cmp(hcount_o, 0, "R11 reset hcount");
    cmp(line_o, 0, "R11 reset line");
    cmp({code_error_o, timing_error_o}, 0, "R11 reset errors");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    wr = 0;
  endtask

  initial begin
    #4000000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0;
    bad   = 0;
    wr    = 0;

    // sweep every status byte behind a preamble (R2); probes 9 bytes apart never lock
    do_reset();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] xb;
      logic [7:0] ref_b;
      exp_t e;
      xb    = 8'(x);
      ref_b = xy(xb[6], xb[5], xb[4]);
      e     = plain(8'hFF);
      e.ck  = 1'b0; e.ckte = 1'b0;
      e.ce  = !(xb[7] && xb[3:0] == ref_b[3:0]);
      push(8'hFF, e);
      e = plain(8'h00); e.ck = 1'b0; e.ckte = 1'b0;
      push(8'h00, e);
      push(8'h00, e);
      e.d = xb;
      push(xb, e);
      idle(5, 1'b0, 0, 0, 1'b0, 1'b0, 1'b0);
    end
    idle(4, 1'b0, 0, 0, 1'b0, 1'b0, 1'b0);

    // phase A: clean start at line 1 (R4 lock on second line), corrupted EAV, saturation
    do_reset();
    idle(3, 1'b0, 0, 0, 1'b0, 1'b0, 1'b1);
    send_line(1, LL, 1'b0, 0, 1'b0, 0, 1'b0, 1'b0);
    for (int l = 2; l <= NL; l++) send_line(l, LL, 1'b1, l, l == 3 || l == 7 || l == 9, 0, 1'b0, 1'b0);
    for (int l = 1; l <= 4; l++) send_line(l, LL, 1'b1, l, 1'b0, 0, 1'b0, 1'b0);
    // R2: bad EAV on line 5 is ignored: counter runs on, line holds
    send_line(5, LL, 1'b1, 4, 1'b0, LL, 1'b0, 1'b1);
    // R10: next EAV is 2*LL after the previous valid one
    send_line(6, LL, 1'b1, 5, 1'b0, 0, 1'b1, 1'b0);
    // R9: field rise realigns the line number
    send_line(7, LL, 1'b1, 7, 1'b1, 0, 1'b0, 1'b0);
    for (int l = 8; l <= NL; l++) send_line(l, LL, 1'b1, l, 1'b0, 0, 1'b0, 1'b0);
    for (int l = 1; l <= 3; l++) send_line(l, LL, 1'b1, l, 1'b0, 0, 1'b0, 1'b0);
    // R3: no further codes, counter saturates
    idle(40, 1'b1, LL, 3, 1'b0, 1'b0, 1'b1);
    idle(4, 1'b0, 0, 0, 1'b0, 1'b0, 1'b0);

    // phase B: mid-frame start with a short first line (R4, R10, R9)
    do_reset();
    send_line(4, LL - 1, 1'b0, 0, 1'b0, 0, 1'b0, 1'b0);
    send_line(5, LL, 1'b0, 0, 1'b0, 0, 1'b1, 1'b0);
    send_line(6, LL, 1'b1, 3, 1'b0, 0, 1'b0, 1'b0);
    send_line(7, LL, 1'b1, 7, 1'b1, 0, 1'b0, 1'b0);
    for (int l = 8; l <= NL; l++) send_line(l, LL, 1'b1, l, l == 9, 0, 1'b0, 1'b0);
    send_line(1, LL, 1'b1, 1, 1'b0, 0, 1'b0, 1'b0);
    send_line(2, LL, 1'b1, 2, 1'b0, 0, 1'b0, 1'b0);
    send_line(3, LL, 1'b1, 3, 1'b1, 0, 1'b0, 1'b0);
    idle(4, 1'b0, 0, 0, 1'b0, 1'b0, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule